// File: doc/BRIEF.md
# Burst Length Planner

This block chooses the beat count for the next frame-data burst of a DMA master on a 32-bit AXI or AHB data bus. For each request it receives the current byte address, the number of bytes still to move, a 5-bit burst preference, a direction (receive writes to memory or transmit reads from memory), an end-of-packet/end-of-buffer marker and a descriptor-access flag. It returns a burst length, a count of surplus beats, and a flag that says whether those surplus beats are zero-filled writes or discarded reads.

A preference field is decoded by priority into a maximum. That maximum is an upper limit: the burst is cut down to the data that remains and to the space left before the next 1 KB address boundary. On the last transfer of a packet or buffer, a per-direction force option can stretch the burst to the full maximum, provided that the stretched burst still fits below the boundary.

Requests arrive on a valid/ready port that accepts one request at a time. Results leave on a second valid/ready port towards the bus master. A result is held unchanged while the master applies back-pressure by keeping `out_ready` low, and it is still held after acceptance until the master pulses `burst_done`. No new request is accepted before that pulse, so `req_ready` doubles as back-pressure towards the requester.

Top module: `burst_len_planner`

## Requirements
- R1: The preference field `req_pref[4:0]` is decoded by priority: bit 4 set gives 16 beats; otherwise bit 3 gives 8; otherwise bit 2 gives 4; otherwise bit 1 or bit 0 gives 1. All zeros gives 256. The result is then clamped to `MAX_BEATS` (default 16), so all zeros gives 16 by default.
- R2: A normal burst is the smallest of three values: the decoded maximum, the remaining beats, and the room before the boundary. Remaining beats are `ceil(req_bytes/4)`, and a zero byte count counts as one beat. The surplus count is 0.
- R3: A burst never crosses a 1 KB boundary. Addresses are beat aligned, and the room is `256 - req_addr[9:2]` beats.
- R4: When `req_dir=0` (receive write), `force_rx=1`, `req_last=1` and the decoded maximum fits in the room, the burst equals the maximum. The surplus is the maximum minus the remaining beats (0 if that is negative), and `out_pad_zero=1` whenever the surplus is nonzero.
- R5: When `req_dir=1` (transmit read), `force_tx=1`, `req_last=1` and the maximum fits in the room, the burst equals the maximum with the same surplus count, and `out_pad_zero=0` (the surplus is discarded).
- R6: If the forced maximum would exceed the room, the normal length of R2 is used and the surplus is 0.
- R7: The force option has no effect when `req_last=0`, or when only the enable of the other direction is set.
- R8: With `req_desc=1` the burst is `DESC_BEATS` (default 4) with no surplus, whatever the preference, force and byte inputs are.
- R9: `req_ready` is high only while the block is idle. An accepted request produces `out_valid` in the next cycle. While `out_ready` is low, `out_valid` and all result outputs stay unchanged.
- R10: After the output handshake, the results stay unchanged and `req_ready` stays low until `burst_done`. `req_ready` returns in the cycle after `burst_done`, and requests offered in the meantime are ignored.
- R11: After reset, `req_ready=1` and `out_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Current byte address (beat aligned) |
| req_bytes | input | CNT_W | Bytes still to move |
| req_pref | input | 5 | Priority-coded burst preference |
| req_dir | input | 1 | 0 receive write, 1 transmit read |
| req_last | input | 1 | Last transfer of packet or buffer |
| req_desc | input | 1 | Descriptor access, fixed length |
| force_rx | input | 1 | Force full bursts at end on receive |
| force_tx | input | 1 | Force full bursts at end on transmit |
| out_valid | output | 1 | Result offered to the master |
| out_ready | input | 1 | Master takes the result |
| out_beats | output | LEN_W | Burst length in beats |
| out_pad | output | LEN_W | Surplus beats in the burst |
| out_pad_zero | output | 1 | Surplus is zero-fill (1) or discard (0) |
| burst_done | input | 1 | Master finished the burst |

## Verification
Assertions check on every cycle that the decoded maximum is a single power of two, and that a computed burst stays below the boundary and within the maximum. They also check that surplus beats appear only on a forced last transfer, that the two handshakes never overlap, and that results hold under back-pressure and while the burst runs. Only the bench scenarios can show that the computed lengths are the right numbers. This covers the priority decode of each preference pattern, the rounding of odd byte counts, the fallback when a forced burst would reach past the boundary, the zero-fill versus discard marking, and that requests offered during a burst are ignored.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int PREF_W     = 5;
  localparam int BURST_CEIL = 256;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_OFFER = 2'd1,
    HS_BUSY  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/bl_pref_decode.sv
module bl_pref_decode #(
  parameter int MAX_BEATS = 16,
  localparam int LEN_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [bl_pkg::PREF_W-1:0] pref,
  output logic [LEN_W-1:0]          max_beats
);
  localparam int RAW_W = $clog2(bl_pkg::BURST_CEIL + 1);

  logic [RAW_W-1:0] raw;

  always_comb begin
    if (pref[4])                 raw = RAW_W'(16);
    else if (pref[3])            raw = RAW_W'(8);
    else if (pref[2])            raw = RAW_W'(4);
    else if (pref[1] || pref[0]) raw = RAW_W'(1);
    else                         raw = RAW_W'(bl_pkg::BURST_CEIL);
  end

  generate
    if (MAX_BEATS < bl_pkg::BURST_CEIL) begin : g_clamp
      assign max_beats = (raw > RAW_W'(MAX_BEATS)) ? LEN_W'(MAX_BEATS) : LEN_W'(raw);
    end else begin : g_full
      assign max_beats = LEN_W'(raw);
    end
  endgenerate

  // R1: the limit is always a single power of two
  p_cap_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(max_beats));
endmodule

// File: rtl/bl_len_calc.sv
module bl_len_calc #(
  parameter int CNT_W      = 16,
  parameter int MAX_BEATS  = 16,
  parameter int DESC_BEATS = 4,
  parameter int BEAT_BYTES = 4,
  parameter int BND_BYTES  = 1024,
  localparam int LEN_W     = $clog2(MAX_BEATS + 1),
  localparam int BEAT_SH   = $clog2(BEAT_BYTES),
  localparam int BND_BEATS = BND_BYTES / BEAT_BYTES,
  localparam int OFS_W     = $clog2(BND_BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] beat_ofs,
  input  logic [CNT_W-1:0] bytes,
  input  logic [LEN_W-1:0] max_beats,
  input  logic             dir_tx,
  input  logic             last,
  input  logic             desc,
  input  logic             force_rx,
  input  logic             force_tx,
  output logic [LEN_W-1:0] beats,
  output logic [LEN_W-1:0] pad,
  output logic             pad_zero
);
  localparam int W = (CNT_W + 1 > OFS_W + 2) ? CNT_W + 1 : OFS_W + 2;

  logic [W-1:0] need, room, cap, nrm;
  logic         force_sel;

  always_comb begin
    need = (W'(bytes) + W'(BEAT_BYTES - 1)) >> BEAT_SH;
    if (need == '0) need = W'(1);
    room = W'(BND_BEATS) - W'(beat_ofs);
    cap  = W'(max_beats);
    nrm  = cap;
    if (need < nrm) nrm = need;
    if (room < nrm) nrm = room;
    force_sel = last && (dir_tx ? force_tx : force_rx);
    if (desc) begin
      beats = LEN_W'(DESC_BEATS);
      pad   = '0;
    end else if (force_sel && (cap <= room)) begin
      beats = max_beats;
      pad   = (need < cap) ? LEN_W'(cap - need) : '0;
    end else begin
      beats = LEN_W'(nrm);
      pad   = '0;
    end
    pad_zero = (pad != '0) && !dir_tx;
  end

  // R3: a frame burst ends at or before the boundary
  p_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !desc |-> (W'(beats) <= room));
  // R2: never above the decoded limit
  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !desc |-> (beats <= max_beats));
  // R7: surplus only on a forced last transfer of the matching direction
  p_pad_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad != '0) |-> (last && !desc && (dir_tx ? force_tx : force_rx)));
endmodule

// File: rtl/bl_handshake.sv
module bl_handshake #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] in_beats,
  input  logic [LEN_W-1:0] in_pad,
  input  logic             in_pad_zero,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LEN_W-1:0] out_beats,
  output logic [LEN_W-1:0] out_pad,
  output logic             out_pad_zero,
  input  logic             burst_done
);
  bl_pkg::hs_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= bl_pkg::HS_IDLE;
      out_beats    <= '0;
      out_pad      <= '0;
      out_pad_zero <= 1'b0;
    end else begin
      case (st)
        bl_pkg::HS_IDLE: if (req_valid) begin
          st           <= bl_pkg::HS_OFFER;
          out_beats    <= in_beats;
          out_pad      <= in_pad;
          out_pad_zero <= in_pad_zero;
        end
        bl_pkg::HS_OFFER: if (out_ready) st <= bl_pkg::HS_BUSY;
        bl_pkg::HS_BUSY:  if (burst_done) st <= bl_pkg::HS_IDLE;
        default: st <= bl_pkg::HS_IDLE;
      endcase
    end
  end

  assign req_ready = (st == bl_pkg::HS_IDLE);
  assign out_valid = (st == bl_pkg::HS_OFFER);

  // R9: the two ports never offer at once
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && req_ready));
  // R9: result held under back-pressure
  p_offer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_beats) && $stable(out_pad)
                                   && $stable(out_pad_zero)));
  // R10: result held while the burst runs
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !req_ready && !burst_done) |=> ($stable(out_beats) && $stable(out_pad)
                                                   && !req_ready));
endmodule

// File: rtl/burst_len_planner.sv
module burst_len_planner #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int MAX_BEATS  = 16,
  parameter int DESC_BEATS = 4,
  parameter int BEAT_BYTES = 4,
  parameter int BND_BYTES  = 1024,
  localparam int LEN_W     = $clog2(MAX_BEATS + 1),
  localparam int BEAT_SH   = $clog2(BEAT_BYTES),
  localparam int BND_SH    = $clog2(BND_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [CNT_W-1:0]          req_bytes,
  input  logic [bl_pkg::PREF_W-1:0] req_pref,
  input  logic                      req_dir,
  input  logic                      req_last,
  input  logic                      req_desc,
  input  logic                      force_rx,
  input  logic                      force_tx,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LEN_W-1:0]          out_beats,
  output logic [LEN_W-1:0]          out_pad,
  output logic                      out_pad_zero,
  input  logic                      burst_done
);
  logic [LEN_W-1:0] max_beats, c_beats, c_pad;
  logic             c_pad_zero;
  logic             unused_addr_bits;

  assign unused_addr_bits = ^{req_addr[ADDR_W-1:BND_SH], req_addr[BEAT_SH-1:0]};

  bl_pref_decode #(.MAX_BEATS(MAX_BEATS)) u_dec (
    .clk(clk), .rst_n(rst_n), .pref(req_pref), .max_beats(max_beats)
  );

  bl_len_calc #(
    .CNT_W(CNT_W), .MAX_BEATS(MAX_BEATS), .DESC_BEATS(DESC_BEATS),
    .BEAT_BYTES(BEAT_BYTES), .BND_BYTES(BND_BYTES)
  ) u_calc (
    .clk(clk), .rst_n(rst_n),
    .beat_ofs(req_addr[BND_SH-1:BEAT_SH]), .bytes(req_bytes),
    .max_beats(max_beats), .dir_tx(req_dir), .last(req_last), .desc(req_desc),
    .force_rx(force_rx), .force_tx(force_tx),
    .beats(c_beats), .pad(c_pad), .pad_zero(c_pad_zero)
  );

  bl_handshake #(.LEN_W(LEN_W)) u_hs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .in_beats(c_beats), .in_pad(c_pad), .in_pad_zero(c_pad_zero),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_beats(out_beats), .out_pad(out_pad), .out_pad_zero(out_pad_zero),
    .burst_done(burst_done)
  );

  // R9: an accepted request is offered in the next cycle
  p_accept_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);
  // R10: ready comes back right after the done pulse
  p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !req_ready && !out_valid) |=> req_ready);
endmodule

// File: tb/sim_burst_len_planner.sv
`timescale 1ns/1ps
module sim_burst_len_planner;
  localparam int LEN_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_dir = 0, req_last = 0, req_desc = 0;
  logic force_rx = 0, force_tx = 0, out_ready = 0, burst_done = 0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_bytes = '0;
  logic [4:0]  req_pref = '0;
  logic req_ready, out_valid, out_pad_zero;
  logic [LEN_W-1:0] out_beats, out_pad;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  burst_len_planner u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_plan(input int addr, input int bytes, input int pref,
      input int dir, input int frx, input int ftx, input int last, input int desc,
      output int b, output int p, output int z);
    int mx, need, room, nb;
    if (desc != 0) begin b = 4; p = 0; z = 0; return; end
    if (pref[4]) mx = 16; else if (pref[3]) mx = 8; else if (pref[2]) mx = 4;
    else if (pref[1] || pref[0]) mx = 1; else mx = 256;
    if (mx > 16) mx = 16;
    need = (bytes + 3) / 4; if (need == 0) need = 1;
    room = 256 - ((addr >> 2) & 255);
    nb = mx; if (need < nb) nb = need; if (room < nb) nb = room;
    if (last != 0 && (dir != 0 ? ftx : frx) != 0 && mx <= room) begin
      b = mx; p = (mx > need) ? mx - need : 0;
    end else begin b = nb; p = 0; end
    z = (p != 0 && dir == 0) ? 1 : 0;
  endfunction

  task automatic txn(input string tag, input int addr, input int bytes, input int pref,
      input int dir, input int frx, input int ftx, input int last, input int desc,
      input int hold, input int busy);
    int eb, ep, ez;
    ref_plan(addr, bytes, pref, dir, frx, ftx, last, desc, eb, ep, ez);
    @(negedge clk);
    req_addr = addr; req_bytes = 16'(bytes); req_pref = 5'(pref); req_dir = dir[0];
    force_rx = frx[0]; force_tx = ftx[0]; req_last = last[0]; req_desc = desc[0];
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R9 valid"}, int'(out_valid), 1);
    chk({tag, " beats"}, int'(out_beats), eb);
    chk({tag, " pad"}, int'(out_pad), ep);
    chk({tag, " pad_zero"}, int'(out_pad_zero), ez);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk({tag, " R9 hold"}, int'(out_valid) + 2 * int'(out_beats), 1 + 2 * eb);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    // R10: requests offered during the burst must be ignored
    req_valid = 1; req_addr = 32'h3FC; req_bytes = 16'd1; req_pref = 5'h02; req_desc = 0;
    for (int i = 0; i < busy; i++) begin
      @(negedge clk);
      chk({tag, " R10 busy ready"}, int'(req_ready), 0);
      chk({tag, " R10 busy beats"}, int'(out_beats) + 64 * int'(out_pad), eb + 64 * ep);
    end
    req_valid = 0; burst_done = 1;
    @(negedge clk);
    burst_done = 0;
    chk({tag, " R10 ready back"}, int'(req_ready), 1);
    chk({tag, " R10 no reoffer"}, int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 ready", int'(req_ready), 1);
    chk("R11 valid", int'(out_valid), 0);
    rst_n = 1;
    // R1 priority decode
    txn("R1 p16", 0, 400, 5'b10011, 0, 0, 0, 0, 0, 1, 1);
    txn("R1 p8",  0, 400, 5'b01111, 0, 0, 0, 0, 0, 0, 0);
    txn("R1 p4",  0, 400, 5'b00111, 1, 0, 0, 0, 0, 2, 2);
    txn("R1 p1a", 0, 400, 5'b00010, 0, 0, 0, 0, 0, 0, 0);
    txn("R1 p1b", 0, 400, 5'b00001, 0, 0, 0, 0, 0, 0, 0);
    txn("R1 p0 clamp", 0, 400, 5'b00000, 0, 0, 0, 0, 0, 0, 0);
    // R2 rounding, zero bytes
    txn("R2 round", 0, 10, 5'b10000, 0, 0, 0, 0, 0, 0, 1);
    txn("R2 zero", 0, 0, 5'b10000, 1, 0, 0, 0, 0, 0, 0);
    // R3 boundary
    txn("R3 room2", 32'h3F8, 100, 5'b10000, 0, 0, 0, 0, 0, 0, 0);
    txn("R3 room1", 32'h7FC, 100, 5'b00000, 1, 0, 0, 0, 0, 0, 0);
    // R4/R5 forced
    txn("R4 rx force", 0, 10, 5'b10000, 0, 1, 0, 1, 0, 1, 1);
    txn("R5 tx force", 32'h100, 10, 5'b01000, 1, 0, 1, 1, 0, 0, 1);
    // R6 forced would cross
    txn("R6 no room", 32'h3F0, 10, 5'b10000, 0, 1, 1, 1, 0, 0, 0);
    // R7 force not applied
    txn("R7 not last", 0, 10, 5'b10000, 0, 1, 1, 0, 0, 0, 0);
    txn("R7 wrong dir", 0, 10, 5'b10000, 0, 0, 1, 1, 0, 0, 0);
    // R8 descriptor
    txn("R8 desc", 32'h3FC, 3, 5'b00001, 0, 1, 1, 1, 1, 0, 0);
    void'($urandom(32'd4242));
    for (int n = 0; n < 300; n++) begin
      int a, by;
      a = ($urandom % 4) == 0 ? int'(32'h400 * ($urandom % 8) + 32'h400 - 4 * ($urandom % 20))
                              : int'(($urandom % 4096) & ~3);
      by = int'($urandom % 200);
      txn("RND", a, by, int'($urandom % 32), int'($urandom % 2), int'($urandom % 2),
          int'($urandom % 2), int'($urandom % 2), ($urandom % 8) == 0 ? 1 : 0,
          int'($urandom % 3), int'($urandom % 3));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule